// File: doc/BRIEF.md
# Chroma Upsampler and Colour Converter

This block turns a stream of luma-and-chroma sample pairs into full-colour pixels. Each input beat carries two luma samples, one even and one odd, together with a single U and a single V sample. The chroma samples are co-sited with the even pixel, so chroma runs at half the luma rate. The block keeps a six-deep sliding window of recent beats. The even pixel uses its own chroma directly. The odd pixel gets chroma from a symmetric six-tap interpolator that runs across the window. At both ends of a line, the first or last chroma sample is repeated to fill the missing taps.

Every beat then produces two RGB pixels. The 18 signed products needed for these pixels are shared over four multipliers on a fixed schedule. Six accumulators collect the partial sums. The results are rounded and clamped to 8 bits, and an output strobe presents both pixels.

The input side is valid/ready. The source must hold a beat and its `in_last` flag stable while `in_valid` is high and `in_ready` is low. A beat is taken on a rising edge where both are high. `in_ready` is high while the block waits for data and in the last cycle of a conversion, and low at all other times. The output has no back-pressure. Each `out_valid` pulse lasts one cycle, and the six channel values are meant to be captured in that cycle.

Top module: `chroma_csc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat is consumed only on an edge where `in_valid` and `in_ready` are both high. `in_ready` stays low during the first seven cycles of every conversion. A held beat is neither lost nor duplicated.
- R3: One conversion takes exactly 8 cycles. `out_valid` pulses last a single cycle and are at least 8 cycles apart. With data always available, results in a line come out exactly 8 cycles apart.
- R4: The even pixel uses Y=`in_y0` with the beat's own U and V. The channels are R=(76284·(Y−16)+104595·(V−128)+32768)>>16, G=(76284·(Y−16)−25624·(U−128)−53281·(V−128)+32768)>>16 and B=(76284·(Y−16)+132251·(U−128)+32768)>>16, with an arithmetic shift.
- R5: The odd pixel of beat k applies the same mapping to Y=`in_y1`. Its chroma is clamp((21·(c[k−2]+c[k+3]) − 52·(c[k−1]+c[k+2]) + 159·(c[k]+c[k+1]) + 128)>>8), where c is the U or V sequence of the line.
- R6: Within a line, a chroma index below 0 takes the line's first sample.
- R7: A chroma index past the end of the line takes its last sample. A line of n beats, with the final beat marked by `in_last`=1, gives exactly n results in input order, including n=1.
- R8: Each output channel saturates at 0 and at 255, and so does each interpolated chroma value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_y0 | input | 8 | Even-pixel luma |
| in_y1 | input | 8 | Odd-pixel luma |
| in_u | input | 8 | U sample co-sited with the even pixel |
| in_v | input | 8 | V sample co-sited with the even pixel |
| in_last | input | 1 | Marks the final beat of a line |
| out_valid | output | 1 | Single-cycle result strobe |
| out_r0 | output | 8 | Even pixel red |
| out_g0 | output | 8 | Even pixel green |
| out_b0 | output | 8 | Even pixel blue |
| out_r1 | output | 8 | Odd pixel red |
| out_g1 | output | 8 | Odd pixel green |
| out_b1 | output | 8 | Odd pixel blue |

## Verification
A random line driven without pauses checks the conversion arithmetic and the exact 8-cycle result spacing. The same kind of line with random idle gaps shows that stalls change only timing and never values or order. Lines of one, three and five beats separate correct edge replication from window handling that assumes at least six beats. Lines of extreme values, with chroma alternating between 0 and 255, drive both the interpolator and the channel outputs into saturation at each end. This exposes clamping that is missing or applied one-sided.

// File: rtl/ccv_pkg.sv
`timescale 1ns/1ps
package ccv_pkg;
  localparam int PIX_W  = 8;
  localparam int OPD_W  = 10;   // offset-removed operand, signed
  localparam int CF_W   = 19;   // signed coefficient width
  localparam int ACC_W  = 32;
  localparam int NCOL   = 3;    // R, G, B
  localparam int NPIX   = 2;    // even, odd
  localparam int NTERM  = 3;    // Y, U, V
  localparam int NCH    = NCOL * NPIX;
  localparam int NPROD  = NCH * NTERM;
  localparam int ITER   = 8;
  localparam int PH_W   = $clog2(ITER);
  localparam int CH_W   = $clog2(NCH);

  typedef struct packed {
    logic [PIX_W-1:0] y0;
    logic [PIX_W-1:0] y1;
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] v;
  } pair_t;

  typedef logic signed [OPD_W-1:0] opd_t;

  typedef enum logic [1:0] {S_WAIT, S_PAD, S_CONV} st_t;

  // Conversion matrix, row = colour, column = term (Y, U, V), scaled by 2^16.
  function automatic logic signed [CF_W-1:0] cf(input int col, input int term);
    case (col * NTERM + term)
      0, 3, 6: cf = 19'sd76284;
      2:       cf = 19'sd104595;
      4:       cf = -19'sd25624;
      5:       cf = -19'sd53281;
      7:       cf = 19'sd132251;
      default: cf = '0;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] sat_pix(input int x);
    if (x < 0)
      sat_pix = '0;
    else if (x > 255)
      sat_pix = '1;
    else
      sat_pix = PIX_W'(x);
  endfunction
endpackage

// File: rtl/ccv_window.sv
`timescale 1ns/1ps
module ccv_window
  import ccv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic             shift,
  input  logic             pad,
  input  pair_t            din,
  output pair_t            cur,
  output logic [PIX_W-1:0] u_mid,
  output logic [PIX_W-1:0] v_mid
);
  localparam int WIN = 6;
  localparam int CTR = WIN / 2 - 1;   // slot of the beat being converted

  pair_t w [WIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) w[i] <= '0;
    end else if (fill) begin
      for (int i = 0; i < WIN; i++) w[i] <= din;
    end else if (shift) begin
      for (int i = 0; i < WIN - 1; i++) w[i] <= w[i+1];
      w[WIN-1] <= pad ? w[WIN-1] : din;
    end
  end

  function automatic logic [PIX_W-1:0] taps6(
    input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
    input logic [PIX_W-1:0] c, input logic [PIX_W-1:0] d,
    input logic [PIX_W-1:0] e, input logic [PIX_W-1:0] f);
    int s;
    s = 21 * (int'(a) + int'(f)) - 52 * (int'(b) + int'(e))
      + 159 * (int'(c) + int'(d)) + 128;
    taps6 = sat_pix(s >>> 8);
  endfunction

  assign cur   = w[CTR];
  assign u_mid = taps6(w[0].u, w[1].u, w[2].u, w[3].u, w[4].u, w[5].u);
  assign v_mid = taps6(w[0].v, w[1].v, w[2].v, w[3].v, w[4].v, w[5].v);
endmodule

// File: rtl/ccv_ctrl.sv
`timescale 1ns/1ps
module ccv_ctrl
  import ccv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  output logic            in_ready,
  output logic            fill,
  output logic            shift,
  output logic            pad,
  output logic            busy,
  output logic [PH_W-1:0] ph
);
  localparam logic [1:0] LOOK = 2'd3;  // lookahead beats needed past the target

  st_t        st, st_n;
  logic [1:0] ahead, ahead_n;
  logic [2:0] remain, remain_n;        // beats in window not yet converted
  logic       first, tail;
  logic       conv_end, take, last_one;

  assign conv_end = (st == S_CONV) && (ph == PH_W'(ITER - 1));
  assign last_one = (remain == 3'd1);
  assign in_ready = (st == S_WAIT) || (conv_end && !tail);
  assign take     = in_valid && in_ready;
  assign fill     = take && first;
  assign pad      = (st == S_PAD) || (conv_end && tail && !last_one);
  assign shift    = (take && !first) || pad;
  assign busy     = (st == S_CONV);

  always_comb begin
    ahead_n = ahead;
    if (fill) ahead_n = '0;
    else if (shift && ahead != LOOK) ahead_n = ahead + 2'd1;

    remain_n = remain;
    if (fill) remain_n = 3'd1;
    else if (take) remain_n = remain + 3'd1;
    if (conv_end) remain_n = remain_n - 3'd1;

    st_n = st;
    case (st)
      S_WAIT: if (take) st_n = (ahead_n == LOOK) ? S_CONV : (in_last ? S_PAD : S_WAIT);
      S_PAD:  if (ahead_n == LOOK) st_n = S_CONV;
      default: if (conv_end) begin
        if (last_one) st_n = S_WAIT;
        else if (tail || take) st_n = S_CONV;
        else st_n = S_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      ph     <= '0;
      ahead  <= '0;
      remain <= '0;
      first  <= 1'b1;
      tail   <= 1'b0;
    end else begin
      st     <= st_n;
      ahead  <= ahead_n;
      remain <= remain_n;
      ph     <= (st == S_CONV) ? ph + PH_W'(1) : '0;
      if (take) begin
        first <= 1'b0;
        tail  <= in_last;
      end else if (conv_end && last_one) begin
        first <= 1'b1;
        tail  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccv_mac.sv
`timescale 1ns/1ps
module ccv_mac
  import ccv_pkg::*;
#(
  parameter int NMUL = 4,
  parameter int FRAC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [PH_W-1:0]  ph,
  input  pair_t            cur,
  input  logic [PIX_W-1:0] u_odd,
  input  logic [PIX_W-1:0] v_odd,
  output logic             res_valid,
  output logic [PIX_W-1:0] res [NCH],
  output logic             pend_any
);
  localparam int HALF = 1 << (FRAC - 1);

  opd_t op [NPIX][NTERM];
  logic signed [ACC_W-1:0] prod_q [NMUL];
  logic                    tag_v  [NMUL];
  logic [CH_W-1:0]         tag_ch [NMUL];
  logic signed [ACC_W-1:0] acc    [NCH];
  logic                    start, finish;

  assign start  = busy && (ph == '0);
  assign finish = busy && (ph == PH_W'(ITER - 1));

  function automatic opd_t offs(input logic [PIX_W-1:0] x, input int o);
    offs = opd_t'({2'b00, x}) - opd_t'(o);
  endfunction

  // Operand capture in phase 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIX; p++)
        for (int t = 0; t < NTERM; t++) op[p][t] <= '0;
    end else if (start) begin
      op[0][0] <= offs(cur.y0, 16);
      op[0][1] <= offs(cur.u, 128);
      op[0][2] <= offs(cur.v, 128);
      op[1][0] <= offs(cur.y1, 16);
      op[1][1] <= offs(u_odd, 128);
      op[1][2] <= offs(v_odd, 128);
    end
  end

  // Shared multipliers: slot s runs on unit s%NMUL in phase 1+s/NMUL.
  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    logic signed [ACC_W-1:0] a_x, k_x;
    logic                    s_ok;
    logic [CH_W-1:0]         s_ch;
    always_comb begin
      int slot, ch, t;
      slot = (int'(ph) - 1) * NMUL + m;
      s_ok = busy && (ph != '0) && (slot < NPROD);
      if (!s_ok) slot = 0;
      ch   = slot / NTERM;
      t    = slot % NTERM;
      s_ch = CH_W'(ch);
      a_x  = ACC_W'(op[ch / NCOL][t]);
      k_x  = ACC_W'(cf(ch % NCOL, t));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[m] <= '0;
        tag_v[m]  <= 1'b0;
        tag_ch[m] <= '0;
      end else begin
        prod_q[m] <= a_x * k_x;    // register stage ahead of the adders
        tag_v[m]  <= s_ok;
        tag_ch[m] <= s_ch;
      end
    end
  end

  always_comb begin
    pend_any = 1'b0;
    for (int m = 0; m < NMUL; m++) pend_any = pend_any | tag_v[m];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_acc
    logic signed [ACC_W-1:0] add;
    always_comb begin
      add = '0;
      for (int m = 0; m < NMUL; m++)
        if (tag_v[m] && tag_ch[m] == CH_W'(c)) add = add + prod_q[m];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[c] <= '0;
        res[c] <= '0;
      end else begin
        acc[c] <= start ? '0 : acc[c] + add;
        if (finish) res[c] <= sat_pix(int'((acc[c] + ACC_W'(HALF)) >>> FRAC));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= finish;
  end
endmodule

// File: rtl/chroma_csc.sv
`timescale 1ns/1ps
module chroma_csc
  import ccv_pkg::*;
#(
  parameter int NMUL = 4,   // at least 4, so that all products land by phase 5
  parameter int FRAC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_y0,
  input  logic [PIX_W-1:0] in_y1,
  input  logic [PIX_W-1:0] in_u,
  input  logic [PIX_W-1:0] in_v,
  input  logic             in_last,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r0,
  output logic [PIX_W-1:0] out_g0,
  output logic [PIX_W-1:0] out_b0,
  output logic [PIX_W-1:0] out_r1,
  output logic [PIX_W-1:0] out_g1,
  output logic [PIX_W-1:0] out_b1
);
  logic             fill, shift, pad, busy, pend_any;
  logic [PH_W-1:0]  ph;
  pair_t            din, cur;
  logic [PIX_W-1:0] u_mid, v_mid;
  logic [PIX_W-1:0] res [NCH];

  assign din = '{y0: in_y0, y1: in_y1, u: in_u, v: in_v};

  ccv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .fill(fill), .shift(shift), .pad(pad),
    .busy(busy), .ph(ph)
  );

  ccv_window u_win (
    .clk(clk), .rst_n(rst_n), .fill(fill), .shift(shift), .pad(pad),
    .din(din), .cur(cur), .u_mid(u_mid), .v_mid(v_mid)
  );

  ccv_mac #(.NMUL(NMUL), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ph(ph), .cur(cur),
    .u_odd(u_mid), .v_odd(v_mid), .res_valid(out_valid), .res(res),
    .pend_any(pend_any)
  );

  assign out_r0 = res[0];
  assign out_g0 = res[1];
  assign out_b0 = res[2];
  assign out_r1 = res[3];
  assign out_g1 = res[4];
  assign out_b1 = res[5];
endmodule

// File: rtl/chroma_csc_chk.sv
`timescale 1ns/1ps
module chroma_csc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       busy,
  input logic [2:0] ph,
  input logic       pend_any
);
  logic [3:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (out_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 4'hF) begin
      gap <= gap + 4'd1;
    end
  end

  // R1: no result strobe while reset is applied
  always @(posedge clk) if (!rst_n) p_quiet_reset_r1: assert (!out_valid);

  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ph != 3'd7 |-> !in_ready);

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen |-> gap >= 4'd7);

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ph != 3'd7 |=> busy && ph == $past(ph) + 3'd1);

  // R4: every product is folded in before rounding starts
  p_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ph == 3'd7 |-> !pend_any);
endmodule

bind chroma_csc chroma_csc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .busy(busy), .ph(ph), .pend_any(pend_any)
);

// File: tb/sim_chroma_csc.sv
`timescale 1ns/1ps
module sim_chroma_csc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_y0 = '0, in_y1 = '0, in_u = '0, in_v = '0;
  logic in_ready, out_valid;
  logic [7:0] out_r0, out_g0, out_b0, out_r1, out_g1, out_b1;

  int checks = 0, fails = 0, cyc = 0;
  int eq[$];
  string cur_req = "R4";
  bit gap_on = 0, have_prev = 0, done = 0;
  int prev_cyc = 0;
  int ly0[64], ly1[64], lu[64], lv[64];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  chroma_csc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_y0(in_y0), .in_y1(in_y1), .in_u(in_u), .in_v(in_v), .in_last(in_last),
    .out_valid(out_valid), .out_r0(out_r0), .out_g0(out_g0), .out_b0(out_b0),
    .out_r1(out_r1), .out_g1(out_g1), .out_b1(out_b1)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int clip(input int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  function automatic int at(input int k, input int n, input bit is_u);
    int j = (k < 0) ? 0 : ((k > n - 1) ? n - 1 : k);
    return is_u ? lu[j] : lv[j];
  endfunction

  function automatic int mid(input int k, input int n, input bit is_u);
    int s = 21 * (at(k-2, n, is_u) + at(k+3, n, is_u)) - 52 * (at(k-1, n, is_u) + at(k+2, n, is_u))
          + 159 * (at(k, n, is_u) + at(k+1, n, is_u)) + 128;
    return clip(s >>> 8);
  endfunction

  task automatic push_rgb(input int y, input int u, input int v);
    int yy = 76284 * (y - 16);
    eq.push_back(clip((yy + 104595 * (v - 128) + 32768) >>> 16));
    eq.push_back(clip((yy - 25624 * (u - 128) - 53281 * (v - 128) + 32768) >>> 16));
    eq.push_back(clip((yy + 132251 * (u - 128) + 32768) >>> 16));
  endtask

  // Output monitor: compares every strobe against the reference queue.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int got[6];
      got = '{out_r0, out_g0, out_b0, out_r1, out_g1, out_b1};
      if (eq.size() < 6) begin
        check("R7 no surplus output", 1, 0);
      end else begin
        for (int i = 0; i < 6; i++) check(cur_req, got[i], eq.pop_front());
      end
      if (gap_on && have_prev) check("R3 streaming spacing", cyc - prev_cyc, 8);
      prev_cyc  = cyc;
      have_prev = 1;
    end
  end

  task automatic send(input int k, input bit last);
    bit ok;
    in_valid = 1'b1;
    in_y0 = 8'(ly0[k]); in_y1 = 8'(ly1[k]); in_u = 8'(lu[k]); in_v = 8'(lv[k]);
    in_last = last;
    forever begin
      #1 ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
  endtask

  task automatic run_line(input int n, input int gap_max, input bit probe);
    for (int k = 0; k < n; k++) begin
      push_rgb(ly0[k], lu[k], lv[k]);
      push_rgb(ly1[k], mid(k, n, 1), mid(k, n, 0));
    end
    for (int k = 0; k < n; k++) begin
      send(k, k == n - 1);
      if (probe && k == 3) begin
        in_valid = 1'b0;
        #1 check("R2 in_ready low in conversion", int'(in_ready), 0);
        @(negedge clk);
      end
      if (gap_max > 0) begin
        in_valid = 1'b0;
        repeat ($urandom_range(gap_max, 0)) @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int lim = 0;
    while (eq.size() > 0 && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    repeat (20) @(negedge clk);
    check(req, eq.size(), 0);
  endtask

  task automatic fill_rand(input int n);
    for (int k = 0; k < n; k++) begin
      ly0[k] = $urandom_range(255, 0); ly1[k] = $urandom_range(255, 0);
      lu[k]  = $urandom_range(255, 0); lv[k]  = $urandom_range(255, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Continuous stream: arithmetic and 8-cycle cadence.
    cur_req = "R4/R5 streaming line";
    fill_rand(16);
    gap_on = 1; have_prev = 0;
    run_line(16, 0, 0);
    drain("R7 count streaming line");
    gap_on = 0;

    // Random stalls, plus in_ready probe after the first conversion starts.
    cur_req = "R2 stalled line";
    fill_rand(12);
    run_line(12, 3, 1);
    drain("R2 count stalled line");

    // Short lines exercise both edges at once.
    cur_req = "R6/R7 one-beat line";
    fill_rand(1);
    run_line(1, 0, 0);
    drain("R7 count one-beat line");
    cur_req = "R6/R7 three-beat line";
    fill_rand(3);
    run_line(3, 1, 0);
    drain("R7 count three-beat line");
    cur_req = "R6/R7 five-beat line";
    fill_rand(5);
    run_line(5, 0, 0);
    drain("R7 count five-beat line");

    // Left edge on a rising chroma ramp.
    cur_req = "R6 ramp line";
    for (int k = 0; k < 8; k++) begin
      ly0[k] = 100; ly1[k] = 150; lu[k] = 20 + 30 * k; lv[k] = 230 - 25 * k;
    end
    run_line(8, 0, 0);
    drain("R7 count ramp line");

    // Saturation at both ends.
    cur_req = "R8 saturation line";
    for (int k = 0; k < 10; k++) begin
      ly0[k] = (k % 2) ? 0 : 255; ly1[k] = (k % 2) ? 255 : 0;
      lu[k]  = (k % 2) ? 255 : 0; lv[k]  = (k % 2) ? 0 : 255;
    end
    run_line(10, 0, 0);
    drain("R8 count saturation line");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule